// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This block is a 32-bit memory-mapped slave that computes the factorial of an unsigned operand, truncated to 32 bits. Software writes the operand, then either polls a busy flag or waits for an interrupt, and reads the result back from the same register. The product is built one multiply per clock by an iterative engine. The accumulator starts at one and is multiplied by an operand that counts down to zero.

The register window also holds a fixed identification word and a liveness register that returns the inverse of what was last written. It also holds an interrupt status word that software can set and acknowledge bit by bit. The single level-sensitive interrupt output is high whenever that word is nonzero. A neighbouring engine can OR its own event bits into the status word through a dedicated set input.

Every access carries a byte count. Only 4-byte accesses reach a register. Reads that are refused, and reads of offsets with no register behind them, return all ones.

Top module: `fact_accel`

## Requirements
- R1: A 4-byte read of offset 0x00 returns 0x010000ED.
- R2: A 4-byte write of value V to offset 0x04 makes later reads of 0x04 return ~V.
- R3: A 4-byte write of N to offset 0x08 sets status bit 0 (busy). When busy clears, offset 0x08 reads N! modulo 2^32, and 0! reads as 1.
- R4: A write to offset 0x08 while busy is ignored, and the computation in progress finishes with its original operand.
- R5: Status at offset 0x20 holds busy in bit 0, which is read-only, and a completion interrupt enable in bit 1, which software reads and writes. Writing 0x20 never changes bit 0.
- R6: When the factorial finishes with the enable set, interrupt status bit 0 is set. With the enable clear, the interrupt status is left unchanged.
- R7: Interrupt status reads at offset 0x24. A write to 0x60 ORs the data into it. A write to 0x64 clears the bits that are one in the data.
- R8: The interrupt output is high exactly when the interrupt status is nonzero, one cycle after the register update.
- R9: Bits driven high on the external set input are ORed into the interrupt status. If an acknowledge of the same bit arrives in the same cycle, the set wins.
- R10: An access whose byte count is not 4 writes nothing, and on a read it returns 0xFFFFFFFF.
- R11: A read of any offset that has no register returns 0xFFFFFFFF.
- R12: Busy stays high for at most 40 consecutive cycles for any 32-bit operand. The engine stops early once the product becomes zero.
- R13: After reset, offsets 0x04, 0x08, 0x20 and 0x24 read zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 20 | Byte offset within the window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| ext_irq_set | input | 32 | Bits ORed into interrupt status by an external engine |
| irq_out | output | 1 | Level interrupt, high while interrupt status is nonzero |

## Verification
The hardest case to reach is an operand write that lands while the engine is still multiplying. The busy window lasts only a few dozen cycles, so the bench issues a second write to 0x08 immediately after the first. It then checks that the result matches the first operand. A second hard case is an external set and a software acknowledge of the same bit in the same cycle. The bench drives the set input during the very cycle of the 0x64 write. Random operands, including values far above 33, exercise the early stop of the multiply loop.

// File: rtl/fact_pkg.sv
package fact_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned OFF_IDENT = 'h00;
  localparam int unsigned OFF_LIVE  = 'h04;
  localparam int unsigned OFF_FACT  = 'h08;
  localparam int unsigned OFF_CTRL  = 'h20;
  localparam int unsigned OFF_ISTAT = 'h24;
  localparam int unsigned OFF_ISET  = 'h60;
  localparam int unsigned OFF_ICLR  = 'h64;
  localparam logic [31:0] IDENT_WORD = 32'h0100_00ED;
  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [0:0] {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

  typedef struct packed {
    logic live;
    logic fact;
    logic ctrl;
    logic iset;
    logic iclr;
  } wr_strobe_t;
endpackage

// File: rtl/fact_engine.sv
module fact_engine
  import fact_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter bit          EARLY_ZERO = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] operand_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o
);
  eng_state_e    state_q, state_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] prod;
  logic          acc_zero;
  logic          finish;
  logic          load_en;

  assign prod = acc_q * cnt_q;

  generate
    if (EARLY_ZERO) begin : g_zero_stop
      assign acc_zero = (acc_q == '0);
    end else begin : g_full_run
      assign acc_zero = 1'b0;
    end
  endgenerate

  assign finish = (state_q == ENG_RUN) && ((cnt_q == '0) || acc_zero);

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    unique case (state_q)
      ENG_IDLE: begin
        if (start_i) begin
          state_d = ENG_RUN;
          acc_d   = {{(DW-1){1'b0}}, 1'b1};
          cnt_d   = operand_i;
          load_en = 1'b1;
        end
      end
      ENG_RUN: begin
        load_en = 1'b1;
        if (finish) begin
          state_d = ENG_IDLE;
        end else begin
          acc_d = prod;
          cnt_d = cnt_q - {{(DW-1){1'b0}}, 1'b1};
        end
      end
      default: state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      acc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o   = (state_q == ENG_RUN);
  assign done_o   = finish;
  assign result_o = acc_q;
endmodule

// File: rtl/fact_irq.sv
module fact_irq #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sw_set_i,
  input  logic [DW-1:0] sw_clr_i,
  input  logic [DW-1:0] ext_set_i,
  input  logic          done_set_i,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, stat_d;
  logic [DW-1:0] set_all;
  logic          upd_en;

  always_comb begin
    set_all    = sw_set_i | ext_set_i;
    set_all[0] = set_all[0] | done_set_i;
    // Sets are applied after the clear so that a simultaneous event is kept.
    stat_d = (stat_q & ~sw_clr_i) | set_all;
    upd_en = (stat_d != stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (upd_en) begin
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/fact_regs.sv
module fact_regs
  import fact_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     bus_rdata,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DW-1:0]     result_i,
  input  logic [DW-1:0]     istat_i,
  output logic              start_o,
  output logic [DW-1:0]     operand_o,
  output logic [DW-1:0]     iset_o,
  output logic [DW-1:0]     iclr_o,
  output logic              irq_en_o,
  output logic [DW-1:0]     fact_o
);
  localparam logic [DW-1:0] ALL_ONES = '1;

  logic          size_ok;
  logic          wr_ok;
  logic          rd_req;
  wr_strobe_t    wr;
  logic [DW-1:0] live_q, live_d;
  logic [DW-1:0] fact_q, fact_d;
  logic          en_q, en_d;
  logic          rvalid_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          live_en, fact_en, en_en;

  assign size_ok = (bus_size == 4'(WORD_BYTES));
  assign wr_ok   = bus_valid && bus_write && size_ok;
  assign rd_req  = bus_valid && !bus_write;

  always_comb begin
    wr.live = wr_ok && (bus_addr == ADDR_W'(OFF_LIVE));
    wr.fact = wr_ok && (bus_addr == ADDR_W'(OFF_FACT));
    wr.ctrl = wr_ok && (bus_addr == ADDR_W'(OFF_CTRL));
    wr.iset = wr_ok && (bus_addr == ADDR_W'(OFF_ISET));
    wr.iclr = wr_ok && (bus_addr == ADDR_W'(OFF_ICLR));
  end

  // Operand lock-out: the engine only accepts a new value while idle.
  assign start_o   = wr.fact && !busy_i;
  assign operand_o = bus_wdata;
  assign iset_o    = wr.iset ? bus_wdata : '0;
  assign iclr_o    = wr.iclr ? bus_wdata : '0;

  always_comb begin
    live_d  = ~bus_wdata;
    live_en = wr.live;
    en_d    = bus_wdata[1];
    en_en   = wr.ctrl;
    fact_en = 1'b0;
    fact_d  = fact_q;
    if (done_i) begin
      fact_d  = result_i;
      fact_en = 1'b1;
    end else if (start_o) begin
      fact_d  = bus_wdata;
      fact_en = 1'b1;
    end
  end

  always_comb begin
    rvalid_d = rd_req;
    rdata_d  = ALL_ONES;
    if (rd_req && size_ok) begin
      if (bus_addr == ADDR_W'(OFF_IDENT)) begin
        rdata_d = DW'(IDENT_WORD);
      end else if (bus_addr == ADDR_W'(OFF_LIVE)) begin
        rdata_d = live_q;
      end else if (bus_addr == ADDR_W'(OFF_FACT)) begin
        rdata_d = fact_q;
      end else if (bus_addr == ADDR_W'(OFF_CTRL)) begin
        rdata_d = {{(DW-2){1'b0}}, en_q, busy_i};
      end else if (bus_addr == ADDR_W'(OFF_ISTAT)) begin
        rdata_d = istat_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q     <= '0;
      fact_q     <= '0;
      en_q       <= 1'b0;
      bus_rvalid <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (live_en) live_q <= live_d;
      if (fact_en) fact_q <= fact_d;
      if (en_en)   en_q   <= en_d;
      bus_rvalid <= rvalid_d;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_en_o  = en_q;
  assign fact_o    = fact_q;
endmodule

// File: rtl/fact_accel.sv
module fact_accel
  import fact_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_W     = 20,
  parameter bit          EARLY_ZERO = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  output logic              bus_rvalid,
  output logic [DW-1:0]     bus_rdata,
  input  logic [DW-1:0]     ext_irq_set,
  output logic              irq_out
);
  logic          busy_w;
  logic          done_w;
  logic          start_w;
  logic          irq_en_w;
  logic [DW-1:0] result_w;
  logic [DW-1:0] operand_w;
  logic [DW-1:0] iset_w;
  logic [DW-1:0] iclr_w;
  logic [DW-1:0] irq_stat;
  logic [DW-1:0] fact_val;

  fact_regs #(.DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .busy_i     (busy_w),
    .done_i     (done_w),
    .result_i   (result_w),
    .istat_i    (irq_stat),
    .start_o    (start_w),
    .operand_o  (operand_w),
    .iset_o     (iset_w),
    .iclr_o     (iclr_w),
    .irq_en_o   (irq_en_w),
    .fact_o     (fact_val)
  );

  fact_engine #(.DW(DW), .EARLY_ZERO(EARLY_ZERO)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_w),
    .operand_i (operand_w),
    .busy_o    (busy_w),
    .done_o    (done_w),
    .result_o  (result_w)
  );

  fact_irq #(.DW(DW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_set_i   (iset_w),
    .sw_clr_i   (iclr_w),
    .ext_set_i  (ext_irq_set),
    .done_set_i (done_w && irq_en_w),
    .stat_o     (irq_stat),
    .irq_o      (irq_out)
  );
endmodule

// File: rtl/fact_accel_chk.sv
module fact_accel_chk #(
  parameter int unsigned DW         = 32,
  parameter int unsigned ADDR_W     = 20,
  parameter bit          EARLY_ZERO = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_size,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     ext_irq_set,
  input logic              irq_out,
  input logic              busy,
  input logic              done,
  input logic              irq_en,
  input logic [DW-1:0]     fact_val,
  input logic [DW-1:0]     irq_stat
);
  localparam int unsigned BUSY_LIMIT = 40;
  logic [7:0] busy_run;
  logic       fact_wr, ctrl_wr, iset_wr, iclr_wr, bad_rd;

  assign fact_wr = bus_valid && bus_write && bus_size == 4'd4 && bus_addr == ADDR_W'('h08);
  assign ctrl_wr = bus_valid && bus_write && bus_size == 4'd4 && bus_addr == ADDR_W'('h20);
  assign iset_wr = bus_valid && bus_write && bus_size == 4'd4 && bus_addr == ADDR_W'('h60);
  assign iclr_wr = bus_valid && bus_write && bus_size == 4'd4 && bus_addr == ADDR_W'('h64);
  assign bad_rd  = bus_valid && !bus_write && bus_size != 4'd4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (!busy) busy_run <= '0;
    else if (busy_run != 8'hFF) busy_run <= busy_run + 8'd1;
  end

  assert_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_size == 4'd4 && bus_addr == '0) |=> bus_rdata == 32'h0100_00ED);

  assert_locked_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fact_wr && busy && !done) |=> $stable(fact_val));

  assert_busy_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !done) |=> busy == $past(busy));

  assert_done_sets_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && irq_en) |=> irq_stat[0]);

  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iclr_wr && ext_irq_set == '0 && !(done && irq_en)) |=> (irq_stat & $past(bus_wdata)) == '0);

  assert_irq_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(ext_irq_set != '0 || (iset_wr && bus_wdata != '0) || (done && irq_en)));

  assert_ext_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq_set != '0) |=> (irq_stat & $past(ext_irq_set)) == $past(ext_irq_set));

  assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |=> bus_rdata == '1);

  generate
    if (EARLY_ZERO) begin : g_bound
      assert_busy_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < 8'(BUSY_LIMIT));
    end
  endgenerate
endmodule

bind fact_accel fact_accel_chk #(.DW(DW), .ADDR_W(ADDR_W), .EARLY_ZERO(EARLY_ZERO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .ext_irq_set (ext_irq_set),
  .irq_out     (irq_out),
  .busy        (busy_w),
  .done        (done_w),
  .irq_en      (irq_en_w),
  .fact_val    (fact_val),
  .irq_stat    (irq_stat)
);

// File: tb/fact_accel_tb.sv
module fact_accel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [19:0] bus_addr = '0;
  logic [3:0]  bus_size = 4'd4;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [31:0] ext_irq_set = '0;
  logic        irq_out;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  fact_accel u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .ext_irq_set(ext_irq_set), .irq_out(irq_out)
  );

  function automatic logic [31:0] ref_fact(input logic [31:0] n);
    logic [31:0] acc = 32'd1;
    logic [31:0] k = n;
    while (k != 0 && acc != 0) begin
      acc = acc * k;
      k = k - 1;
    end
    return acc;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_size = 4'd4;
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d, input logic [3:0] sz = 4'd4);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_size = 4'd4;
    d = bus_rdata;
  endtask

  task automatic wait_idle(input string req, output int polls);
    logic [31:0] s;
    polls = 0;
    do begin
      rd(20'h20, s);
      polls++;
    end while (s[0] && polls < 60);
    check(req, {31'b0, s[0]}, 32'd0);
  endtask

  task automatic run_fact(input string req, input logic [31:0] n);
    logic [31:0] r;
    int p;
    wr(20'h08, n);
    wait_idle(req, p);
    rd(20'h08, r);
    check(req, r, ref_fact(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, m, v;
    int p;
    void'($urandom(32'd1451));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13 reset state
    rd(20'h04, r); check("R13", r, 32'd0);
    rd(20'h08, r); check("R13", r, 32'd0);
    rd(20'h20, r); check("R13", r, 32'd0);
    rd(20'h24, r); check("R13", r, 32'd0);
    check("R13", {31'b0, irq_out}, 32'd0);

    // R1 identification
    rd(20'h00, r); check("R1", r, 32'h0100_00ED);

    // R2 liveness, random values
    for (int i = 0; i < 8; i++) begin
      v = $urandom;
      wr(20'h04, v);
      rd(20'h04, r); check("R2", r, ~v);
    end

    // R3 directed corners and busy flag
    wr(20'h08, 32'd5);
    rd(20'h20, r); check("R3", {31'b0, r[0]}, 32'd1);
    wait_idle("R3", p);
    rd(20'h08, r); check("R3", r, 32'd120);
    run_fact("R3", 32'd0);
    run_fact("R3", 32'd1);
    run_fact("R3", 32'd12);
    run_fact("R3", 32'd13);

    // R12 large operands finish quickly with zero
    run_fact("R12", 32'd34);
    run_fact("R12", 32'hFFFF_FFFF);
    run_fact("R12", 32'h8000_0000);
    run_fact("R12", 32'd33);

    // R4 operand written during computation is ignored
    wr(20'h08, 32'd20);
    wr(20'h08, 32'd3);
    wait_idle("R4", p);
    rd(20'h08, r); check("R4", r, ref_fact(32'd20));

    // R5 enable bit read/write; bit 0 untouched
    wr(20'h20, 32'h0000_0003);
    rd(20'h20, r); check("R5", r, 32'h0000_0002);
    wr(20'h08, 32'd15);
    wr(20'h20, 32'h0000_0000);
    rd(20'h20, r); check("R5", r, 32'h0000_0001);
    wait_idle("R5", p);

    // R6 completion without enable leaves interrupt status clear
    rd(20'h24, r); check("R6", r, 32'd0);
    wr(20'h20, 32'h0000_0002);
    run_fact("R6", 32'd6);
    rd(20'h24, r); check("R6", r, 32'd1);
    check("R8", {31'b0, irq_out}, 32'd1);
    wr(20'h64, 32'd1);
    rd(20'h24, r); check("R7", r, 32'd0);
    check("R8", {31'b0, irq_out}, 32'd0);
    wr(20'h20, 32'h0000_0000);

    // R7 / R8 random set and acknowledge against a model
    m = 32'd0;
    for (int i = 0; i < 40; i++) begin
      v = $urandom;
      if ($urandom % 4 == 0) v = v & 32'h0000_0F00;
      if ($urandom % 2 == 0) begin
        wr(20'h60, v); m = m | v;
      end else begin
        wr(20'h64, v); m = m & ~v;
      end
      rd(20'h24, r); check("R7", r, m);
      check("R8", {31'b0, irq_out}, {31'b0, m != 0});
    end
    wr(20'h64, 32'hFFFF_FFFF);
    check("R8", {31'b0, irq_out}, 32'd0);

    // R9 external set, also colliding with an acknowledge
    @(negedge clk) ext_irq_set = 32'h0000_0030;
    @(negedge clk) ext_irq_set = '0;
    rd(20'h24, r); check("R9", r, 32'h0000_0030);
    ext_irq_set = 32'h0000_0020;
    wr(20'h64, 32'h0000_0030);
    ext_irq_set = '0;
    rd(20'h24, r); check("R9", r, 32'h0000_0020);
    wr(20'h64, 32'hFFFF_FFFF);

    // R10 wrong access sizes
    wr(20'h04, 32'h1234_5678);
    wr(20'h04, 32'h0000_0000, 4'd2);
    rd(20'h04, r); check("R10", r, ~32'h1234_5678);
    rd(20'h04, r, 4'd8); check("R10", r, 32'hFFFF_FFFF);
    rd(20'h00, r, 4'd1); check("R10", r, 32'hFFFF_FFFF);
    wr(20'h08, 32'd7, 4'd1);
    rd(20'h20, r); check("R10", r, 32'd0);
    wr(20'h60, 32'h1, 4'd2);
    check("R10", {31'b0, irq_out}, 32'd0);

    // R11 unmapped offsets
    rd(20'h10, r); check("R11", r, 32'hFFFF_FFFF);
    rd(20'h80, r); check("R11", r, 32'hFFFF_FFFF);
    rd(20'h60, r); check("R11", r, 32'hFFFF_FFFF);
    rd(20'hF_FFFC, r); check("R11", r, 32'hFFFF_FFFF);

    // R3 random operands including lock-out attempts (R4)
    for (int i = 0; i < 30; i++) begin
      v = ($urandom % 3 == 0) ? $urandom : ($urandom % 40);
      wr(20'h08, v);
      if ($urandom % 2 == 0) wr(20'h08, $urandom % 10);
      wait_idle("R12", p);
      rd(20'h08, r); check("R3", r, ref_fact(v));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule